// File: doc/BRIEF.md
# Multi-Polynomial CRC Register Peripheral

This block is a CRC accumulator that sits on a simple single-cycle 32-bit register bus. Software configures it through a control register, preloads the running checksum with all zeros or all ones, and then writes bytes, half-words or words to a data port. Each accepted data write is conditioned and then folded into the running checksum one byte per clock. The input conditioning can reorder byte lanes and mirror the bits inside each byte. The checksum is non-reflected and is shifted most significant bit first.

Four generator polynomials can be selected at run time: one 32-bit and three 16-bit. The running checksum reads back through two views. One view is the value itself. The other is the same value with all 32 bits mirrored. A wait output stays high while a multi-byte write is still being folded in. While it is high the bus master must hold its access, so no write is lost and none is taken twice.

Top module: `crc_unit`

## Requirements
- R1: After reset the control word reads 0x0000_0000, the checksum reads 0x0000_0000 and `bus_wait` is low.
- R2: Control word (offset 0x00) holds seed value at bit 1, engine enable at bit 2, polynomial select at bits 5:4, force-byte at bit 8, bit-mirror at bit 9 and lane order at bits 11:10. Bit 0 and every other bit always read 0. Control writes take the whole word whatever `bus_be` is.
- R3: A write to offset 0x04 ORs the written bits into the control word. A write to offset 0x08 clears every control bit that is 1 in the written value. Both offsets read back the control word.
- R4: Writing bit 0 as 1 through offset 0x00 or 0x04 loads the checksum at that clock edge. The loaded value is 0xFFFF_FFFF if the resulting bit 1 is 1, and 0 if it is 0.
- R5: Polynomial select 0 uses 32-bit 0x04C11DB7. Select 1 uses 16-bit 0x1021, select 2 uses 16-bit 0x3D65 and select 3 uses 16-bit 0x8005. Each byte is XORed into the top byte of the active width and shifted MSB first with no reflection.
- R6: With force-byte clear, the write size comes from `bus_be`. 1111 is a word. 0011 and 1100 are half-words. A single set lane is a byte. Any other pattern adds nothing. Bytes are taken from the strobed lanes.
- R7: With force-byte set, any nonzero `bus_be` adds exactly one byte, taken from the lowest strobed lane.
- R8: For a word with lanes B3 B2 B1 B0, lane order 0 and 3 fold in B3,B2,B1,B0. Order 1 folds in B2,B3,B0,B1. Order 2 folds in B0,B1,B2,B3. For a half-word B1 B0, order 0 and 3 fold in B1,B0, while orders 1 and 2 fold in B0,B1.
- R9: With bit-mirror set, the bits of each byte are reversed before it is folded in.
- R10: Data writes (offset 0x10) leave the checksum unchanged while the engine enable bit is 0.
- R11: Offset 0x10 reads the checksum, with bits 31:16 forced to 0 when a 16-bit polynomial is selected. Offset 0x20 reads that value with all 32 bits mirrored. Misaligned addresses and any other offset read 0 and ignore writes.
- R12: An accepted data write of N bytes holds `bus_wait` high for exactly N cycles, starting the edge after acceptance. No write of any kind is accepted while `bus_wait` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write request, held by the master until accepted |
| bus_be | input | 4 | Byte lane strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| bus_wait | output | 1 | High while bytes remain to fold in; writes are not accepted |

## Verification
A seed load, a control write and a read all take effect at the edge of the accepted write, so the bench reads them back at the next falling edge. A data write of N bytes raises `bus_wait` at the falling edge after acceptance. The bench counts the falling edges during which `bus_wait` stays high and compares the count with N. Checksum values are read only once `bus_wait` has dropped, which is N edges after acceptance, when the last byte has been folded in. The hold test keeps a second write asserted across the busy window. It then confirms that the final checksum contains that second word exactly once.

// File: rtl/crc_unit_pkg.sv
package crc_unit_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned LANES   = WORD_W / 8;
    localparam int unsigned CNT_W   = $clog2(LANES + 1);

    // word offsets (byte offset >> 2)
    localparam logic [3:0] OFS_CTRL = 4'h0;
    localparam logic [3:0] OFS_SET  = 4'h1;
    localparam logic [3:0] OFS_CLR  = 4'h2;
    localparam logic [3:0] OFS_DATA = 4'h4;
    localparam logic [3:0] OFS_REV  = 4'h8;

    localparam logic [WORD_W-1:0] CTRL_WMASK = 32'h0000_0F36;

    typedef struct packed {
        logic [1:0] order;
        logic       bit_flip;
        logic       byte_force;
        logic [1:0] poly_sel;
        logic       run;
        logic       seed_ones;
    } ctrl_t;

    function automatic logic [WORD_W-1:0] ctrl_pack(ctrl_t c);
        return {20'b0, c.order, c.bit_flip, c.byte_force, 2'b0,
                c.poly_sel, 1'b0, c.run, c.seed_ones, 1'b0};
    endfunction

    function automatic ctrl_t ctrl_unpack(logic [WORD_W-1:0] w);
        ctrl_t c;
        c.order      = w[11:10];
        c.bit_flip   = w[9];
        c.byte_force = w[8];
        c.poly_sel   = w[5:4];
        c.run        = w[2];
        c.seed_ones  = w[1];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] mirror_word(logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = w[WORD_W-1-i];
        return r;
    endfunction

    // one byte, MSB first, non-reflected
    function automatic logic [WORD_W-1:0] crc_fold(logic [WORD_W-1:0] crc,
                                                   logic [7:0] b,
                                                   logic [WORD_W-1:0] poly,
                                                   logic narrow);
        logic [WORD_W-1:0] c;
        logic              top;
        c = crc;
        if (narrow) c[15:8]  = c[15:8] ^ b;
        else        c[31:24] = c[31:24] ^ b;
        for (int i = 0; i < 8; i++) begin
            top = narrow ? c[15] : c[31];
            c   = c << 1;
            if (top) c = c ^ poly;
        end
        if (narrow) c[31:16] = '0;
        return c;
    endfunction

endpackage

// File: rtl/crc_unit_ctrl.sv
module crc_unit_ctrl
    import crc_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl_o,
    output logic              seed_go,
    output logic              seed_ones
);

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        logic [WORD_W-1:0] cur;
        cur    = ctrl_pack(ctrl_q);
        ctrl_d = ctrl_q;
        if (wr_ctrl)     ctrl_d = ctrl_unpack(wdata & CTRL_WMASK);
        else if (wr_set) ctrl_d = ctrl_unpack(cur | (wdata & CTRL_WMASK));
        else if (wr_clr) ctrl_d = ctrl_unpack(cur & ~wdata);
        seed_go   = (wr_ctrl | wr_set) & wdata[0];
        seed_ones = ctrl_d.seed_ones;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_o = ctrl_q;

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((ctrl_pack(ctrl_q) & $past(wdata) & CTRL_WMASK)
                    == ($past(wdata) & CTRL_WMASK)));

    assert_clr_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((ctrl_pack(ctrl_q) & $past(wdata)) == '0));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_pack(ctrl_q) & ~CTRL_WMASK) == '0);

endmodule

// File: rtl/crc_unit_feed.sv
module crc_unit_feed
    import crc_unit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  ctrl_t             ctrl,
    output logic [CNT_W-1:0]  nbytes,
    output logic [WORD_W-1:0] seq
);

    logic [WORD_W-1:0] ordered;
    logic [WORD_W-1:0] aligned;
    logic [1:0]        lo;

    always_comb begin
        lo = '0;
        for (int i = LANES - 1; i >= 0; i--) if (be[i]) lo = 2'(i);
        aligned = wdata >> {lo, 3'b000};

        if (ctrl.byte_force) begin
            nbytes = (be != '0) ? CNT_W'(1) : CNT_W'(0);
        end else begin
            unique case (be)
                4'b1111:                            nbytes = CNT_W'(4);
                4'b0011, 4'b1100:                   nbytes = CNT_W'(2);
                4'b0001, 4'b0010, 4'b0100, 4'b1000: nbytes = CNT_W'(1);
                default:                            nbytes = CNT_W'(0);
            endcase
        end

        // first byte to fold lands in [31:24]
        unique case (nbytes)
            CNT_W'(4): begin
                unique case (ctrl.order)
                    2'd1:    ordered = {aligned[23:16], aligned[31:24],
                                        aligned[7:0],   aligned[15:8]};
                    2'd2:    ordered = {aligned[7:0],   aligned[15:8],
                                        aligned[23:16], aligned[31:24]};
                    default: ordered = aligned;
                endcase
            end
            CNT_W'(2): begin
                if (ctrl.order == 2'd1 || ctrl.order == 2'd2)
                    ordered = {aligned[7:0], aligned[15:8], 16'b0};
                else
                    ordered = {aligned[15:0], 16'b0};
            end
            default: ordered = {aligned[7:0], 24'b0};
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_byte;
        always_comb begin
            for (int k = 0; k < 8; k++)
                lane_byte[k] = ctrl.bit_flip ? ordered[8*g + 7 - k] : ordered[8*g + k];
        end
        assign seq[8*g +: 8] = lane_byte;
    end

    assert_width_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nbytes == CNT_W'(0)) || (nbytes == CNT_W'(1)) ||
        (nbytes == CNT_W'(2)) || (nbytes == CNT_W'(4)));

    assert_force_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.byte_force |-> (nbytes <= CNT_W'(1)));

endmodule

// File: rtl/crc_unit_core.sv
module crc_unit_core
    import crc_unit_pkg::*;
#(
    parameter logic [31:0] POLY_WIDE = 32'h04C1_1DB7,
    parameter logic [15:0] POLY_N1   = 16'h1021,
    parameter logic [15:0] POLY_N2   = 16'h3D65,
    parameter logic [15:0] POLY_N3   = 16'h8005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [CNT_W-1:0]  nbytes,
    input  logic [WORD_W-1:0] seq,
    input  logic              seed_go,
    input  logic              seed_ones,
    input  logic [1:0]        poly_sel,
    output logic [WORD_W-1:0] crc_o,
    output logic              busy_o
);

    typedef struct packed {
        logic [WORD_W-1:0] crc;
        logic [WORD_W-1:0] shreg;
        logic [CNT_W-1:0]  left;
    } core_t;

    core_t d, q;
    logic [WORD_W-1:0] poly;
    logic              narrow;

    always_comb begin
        narrow = (poly_sel != 2'd0);
        unique case (poly_sel)
            2'd0:    poly = POLY_WIDE;
            2'd1:    poly = {16'b0, POLY_N1};
            2'd2:    poly = {16'b0, POLY_N2};
            default: poly = {16'b0, POLY_N3};
        endcase

        d = q;
        if (seed_go) begin
            d.crc = seed_ones ? '1 : '0;
        end else if (q.left != '0) begin
            d.crc   = crc_fold(q.crc, q.shreg[WORD_W-1 -: 8], poly, narrow);
            d.shreg = q.shreg << 8;
            d.left  = q.left - CNT_W'(1);
        end
        if (load) begin
            d.shreg = seq;
            d.left  = nbytes;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign crc_o  = q.crc;
    assign busy_o = (q.left != '0);

    assert_load_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy_o);

    assert_busy_length_R12: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q.left == $past(nbytes)));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !load && !seed_go) |=> $stable(crc_o));

    assert_seed_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
        seed_go |=> (crc_o == ($past(seed_ones) ? '1 : '0)));

endmodule

// File: rtl/crc_unit.sv
module crc_unit
    import crc_unit_pkg::*;
#(
    parameter int unsigned ADDR_W    = 6,
    parameter logic [31:0] POLY_WIDE = 32'h04C1_1DB7,
    parameter logic [15:0] POLY_N1   = 16'h1021,
    parameter logic [15:0] POLY_N2   = 16'h3D65,
    parameter logic [15:0] POLY_N3   = 16'h8005
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_wait
);

    localparam int unsigned IDX_W = ADDR_W - 2;

    ctrl_t             ctrl;
    logic              seed_go, seed_ones, busy, accept, aligned;
    logic              wr_ctrl, wr_set, wr_clr, wr_data, load;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  nbytes;
    logic [WORD_W-1:0] seq, crc, data_view;

    assign idx     = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign accept  = bus_wr & ~busy & aligned;
    assign wr_ctrl = accept && (idx == IDX_W'(OFS_CTRL));
    assign wr_set  = accept && (idx == IDX_W'(OFS_SET));
    assign wr_clr  = accept && (idx == IDX_W'(OFS_CLR));
    assign wr_data = accept && (idx == IDX_W'(OFS_DATA));
    assign load    = wr_data & ctrl.run & (nbytes != '0);

    crc_unit_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_set    (wr_set),
        .wr_clr    (wr_clr),
        .wdata     (bus_wdata),
        .ctrl_o    (ctrl),
        .seed_go   (seed_go),
        .seed_ones (seed_ones)
    );

    crc_unit_feed u_feed (
        .clk    (clk),
        .rst_n  (rst_n),
        .wdata  (bus_wdata),
        .be     (bus_be),
        .ctrl   (ctrl),
        .nbytes (nbytes),
        .seq    (seq)
    );

    crc_unit_core #(
        .POLY_WIDE (POLY_WIDE),
        .POLY_N1   (POLY_N1),
        .POLY_N2   (POLY_N2),
        .POLY_N3   (POLY_N3)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .nbytes    (nbytes),
        .seq       (seq),
        .seed_go   (seed_go),
        .seed_ones (seed_ones),
        .poly_sel  (ctrl.poly_sel),
        .crc_o     (crc),
        .busy_o    (busy)
    );

    assign data_view = (ctrl.poly_sel != 2'd0) ? {16'b0, crc[15:0]} : crc;

    always_comb begin
        bus_rdata = '0;
        if (aligned) begin
            if (idx == IDX_W'(OFS_CTRL) || idx == IDX_W'(OFS_SET) || idx == IDX_W'(OFS_CLR))
                bus_rdata = ctrl_pack(ctrl);
            else if (idx == IDX_W'(OFS_DATA))
                bus_rdata = data_view;
            else if (idx == IDX_W'(OFS_REV))
                bus_rdata = mirror_word(data_view);
        end
    end

    assign bus_wait = busy;

    assert_narrow_upper_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.poly_sel != 2'd0 && aligned && idx == IDX_W'(OFS_DATA))
            |-> (bus_rdata[31:16] == 16'h0000));

    assert_ctrl_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl));

endmodule

// File: tb/crc_unit_tb_top.sv
module crc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_wait;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_crc  = '0;

    always #5 clk = ~clk;

    crc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_wait(bus_wait)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] rev32(input logic [31:0] w);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = w[31-i];
        return r;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b,
                                             input logic [1:0] sel);
        logic [31:0] p;
        int          w;
        w = (sel == 0) ? 32 : 16;
        p = (sel == 0) ? 32'h04C11DB7 : (sel == 1) ? 32'h1021 : (sel == 2) ? 32'h3D65 : 32'h8005;
        if (w == 16) c = c & 32'hFFFF;
        c = c ^ ({24'b0, b} << (w - 8));
        for (int i = 0; i < 8; i++) begin
            if (c[w-1]) c = (c << 1) ^ p;
            else        c = c << 1;
            if (w == 16) c = c & 32'hFFFF;
        end
        return c;
    endfunction

    function automatic int ref_n(input logic [3:0] be, input logic force1);
        if (force1) return (be != 0) ? 1 : 0;
        case (be)
            4'b1111: return 4;
            4'b0011, 4'b1100: return 2;
            4'b0001, 4'b0010, 4'b0100, 4'b1000: return 1;
            default: return 0;
        endcase
    endfunction

    // fold a data write into the model, return the byte count
    function automatic int ref_data(input logic [3:0] be, input logic [31:0] w);
        int         n, lo;
        logic [7:0] b[4];
        logic [7:0] s[4];
        n  = ref_n(be, m_ctrl[8]);
        lo = 0;
        for (int i = 3; i >= 0; i--) if (be[i]) lo = i;
        for (int i = 0; i < 4; i++) b[i] = 8'(w >> (8 * (lo + i)));
        if (n == 4 && m_ctrl[11:10] == 1)      begin s[0]=b[2]; s[1]=b[3]; s[2]=b[0]; s[3]=b[1]; end
        else if (n == 4 && m_ctrl[11:10] == 2) begin s[0]=b[0]; s[1]=b[1]; s[2]=b[2]; s[3]=b[3]; end
        else if (n == 4)                       begin s[0]=b[3]; s[1]=b[2]; s[2]=b[1]; s[3]=b[0]; end
        else if (n == 2 && (m_ctrl[11:10] == 1 || m_ctrl[11:10] == 2)) begin s[0]=b[0]; s[1]=b[1]; s[2]=0; s[3]=0; end
        else if (n == 2)                       begin s[0]=b[1]; s[1]=b[0]; s[2]=0; s[3]=0; end
        else                                   begin s[0]=b[0]; s[1]=0; s[2]=0; s[3]=0; end
        if (!m_ctrl[2]) return 0;
        for (int i = 0; i < n; i++) m_crc = ref_step(m_crc, m_ctrl[9] ? rev8(s[i]) : s[i], m_ctrl[5:4]);
        return n;
    endfunction

    task automatic bus_write(input logic [5:0] a, input logic [3:0] be, input logic [31:0] w);
        int exp_n, cnt;
        @(negedge clk);
        while (bus_wait) @(negedge clk);
        bus_addr = a; bus_be = be; bus_wdata = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        exp_n = 0;
        case (a)
            6'h00: m_ctrl = w & 32'h0F36;
            6'h04: m_ctrl = m_ctrl | (w & 32'h0F36);
            6'h08: m_ctrl = m_ctrl & ~w;
            6'h10: exp_n = ref_data(be, w);
            default: ;
        endcase
        if ((a == 6'h00 || a == 6'h04) && w[0]) m_crc = m_ctrl[1] ? 32'hFFFFFFFF : 32'h0;
        cnt = 0;
        while (bus_wait) begin cnt++; @(negedge clk); end
        if (a == 6'h10) chk("R12 wait cycles", 32'(cnt), 32'(exp_n));
    endtask

    task automatic read_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        chk(req, bus_rdata, exp);
    endtask

    function automatic logic [31:0] view();
        return (m_ctrl[5:4] != 0) ? (m_crc & 32'hFFFF) : m_crc;
    endfunction

    task automatic check_views(input string req);
        read_chk(req, 6'h10, view());
        read_chk({req, " R11 mirror"}, 6'h20, rev32(view()));
    endtask

    task automatic feed_string(input logic [31:0] ctrlw, input logic [31:0] exp, input string req);
        string s = "123456789";
        bus_write(6'h00, 4'hF, ctrlw);
        for (int i = 0; i < 9; i++) bus_write(6'h10, 4'b0001, {24'b0, 8'(s[i])});
        read_chk(req, 6'h10, exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] a_w, b_w;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        read_chk("R1 ctrl", 6'h00, 32'h0);
        read_chk("R1 crc", 6'h10, 32'h0);
        chk("R1 wait", {31'b0, bus_wait}, 32'h0);
        rst_n = 1'b1;

        // R2 writable layout, bit 0 and reserved read zero
        bus_write(6'h00, 4'b0001, 32'hFFFF_FFFE);
        read_chk("R2 layout", 6'h00, 32'h0000_0F36);
        // R3 aliases
        bus_write(6'h08, 4'hF, 32'h0000_0330);
        read_chk("R3 clear alias", 6'h08, 32'h0000_0C06);
        bus_write(6'h04, 4'hF, 32'h0000_0010);
        read_chk("R3 set alias", 6'h04, 32'h0000_0C16);

        // R4 seeds
        bus_write(6'h00, 4'hF, 32'h0000_0007);
        read_chk("R4 seed ones", 6'h10, 32'hFFFF_FFFF);
        read_chk("R4 seed self-clear", 6'h00, 32'h0000_0006);
        bus_write(6'h08, 4'hF, 32'h0000_0002);
        bus_write(6'h04, 4'hF, 32'h0000_0001);
        read_chk("R4 seed zeros", 6'h10, 32'h0);

        // R5 known check values, "123456789" byte by byte
        feed_string(32'h0000_0007, 32'h0376_E6E7, "R5 poly0 ones");
        feed_string(32'h0000_0017, 32'h0000_29B1, "R5 poly1 ones");
        feed_string(32'h0000_0015, 32'h0000_31C3, "R5 poly1 zeros");
        feed_string(32'h0000_0025, 32'h0000_3D48, "R5 poly2 zeros");
        feed_string(32'h0000_0035, 32'h0000_FEE8, "R5 poly3 zeros");

        // R6 widths and ignored strobe pattern
        bus_write(6'h00, 4'hF, 32'h0000_0007);
        bus_write(6'h10, 4'b1100, 32'hA1B2_C3D4);
        check_views("R6 upper half");
        bus_write(6'h10, 4'b0100, 32'h0055_0000);
        check_views("R6 lane2 byte");
        bus_write(6'h10, 4'b0101, 32'h1234_5678);
        check_views("R6 odd strobes ignored");

        // R7 forced byte
        bus_write(6'h04, 4'hF, 32'h0000_0100);
        bus_write(6'h10, 4'b1110, 32'hDEAD_BEEF);
        check_views("R7 force byte");
        bus_write(6'h08, 4'hF, 32'h0000_0100);

        // R8 orders on words and half-words
        for (int o = 0; o < 4; o++) begin
            bus_write(6'h00, 4'hF, 32'h0000_0007 | (o << 10));
            bus_write(6'h10, 4'hF, 32'h0102_0304);
            check_views("R8 word order");
            bus_write(6'h10, 4'b0011, 32'h0000_8001);
            check_views("R8 half order");
        end

        // R9 bit mirror
        bus_write(6'h00, 4'hF, 32'h0000_0207);
        bus_write(6'h10, 4'hF, 32'h1357_9BDF);
        check_views("R9 mirror");

        // R10 disabled engine ignores data
        bus_write(6'h08, 4'hF, 32'h0000_0004);
        a_w = view();
        bus_write(6'h10, 4'hF, 32'hCAFE_F00D);
        read_chk("R10 disabled", 6'h10, a_w);

        // R11 unused offset and misaligned read
        read_chk("R11 unused", 6'h0C, 32'h0);
        read_chk("R11 misaligned", 6'h11, 32'h0);

        // R12 held write across busy window is taken once
        bus_write(6'h00, 4'hF, 32'h0000_0007);
        a_w = 32'h1111_2222; b_w = 32'h3333_4444;
        @(negedge clk);
        bus_addr = 6'h10; bus_be = 4'hF; bus_wdata = a_w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wdata = b_w;
        while (bus_wait) @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        while (bus_wait) @(negedge clk);
        void'(ref_data(4'hF, a_w));
        void'(ref_data(4'hF, b_w));
        check_views("R12 held write");

        // random mix
        for (int it = 0; it < 400; it++) begin
            int          kind;
            logic [3:0]  be;
            logic [3:0]  pats[8] = '{4'hF, 4'h3, 4'hC, 4'h1, 4'h2, 4'h4, 4'h8, 4'h0};
            kind = $urandom_range(0, 9);
            if (kind == 0)      bus_write(6'h00, 4'hF, ($urandom & 32'hFFFF_FFFE) | 32'h4);
            else if (kind == 1) bus_write(6'h04, 4'hF, $urandom & 32'h0000_0F33);
            else if (kind == 2) bus_write(6'h08, 4'hF, $urandom & 32'h0000_0F32);
            else begin
                be = pats[$urandom_range(0, 7)];
                if (be == 0) be = 4'($urandom);
                bus_write(6'h10, be, $urandom);
            end
            if (it % 8 == 0) read_chk("R2 random ctrl", 6'h00, m_ctrl);
            check_views("R5 random crc");
        end

        summary();
        $finish;
    end

endmodule